// File: doc/BRIEF.md
# Subcode Bit-Serial Output with Sync Strobe

The block sends 8-bit subcode bytes one bit at a time on a line that runs next to a serial audio stream. Its timing comes from the audio word clock. Each byte takes twelve bit slots, and every half word-clock period is one slot. A byte therefore lasts six word-clock periods, which is the time in which 24 bytes of stereo audio data go by.

A sync strobe goes with the most significant bit of every byte. A receiver uses it to find the byte framing on the subcode line. When a byte is flagged as a subcode frame sync, the strobe is twice as wide. Bytes come in through a valid/ready handshake into a one-entry holding register. If no byte is waiting when a new byte period starts, the block sends a zero byte.

When upsampling is on, the word clock runs four times faster. The subcode bit timing stays the same: an internal divider advances one slot on every fourth word-clock edge.

Top module: `subcode_serial_out`

## Requirements
- R1: During synchronous active-high reset and after it, `sc_data` and `sc_sync` are low and `in_ready` is high. Both outputs stay low until the first slot advance, which starts the first byte period.
- R2: With `upsample` low, every change of the `wclk` level advances one bit slot. `sc_data` and `sc_sync` are registered. They change only on the clock edge that first samples the new `wclk` level, and they hold their value between slot advances.
- R3: A byte period has 12 slots, numbered 0 to 11. In slot 0 `sc_data` is 1 (start). In slots 1 to 8 it carries bits 7 down to 0 of the byte. In slots 9 to 11 it is 0.
- R4: For a byte whose frame-sync flag is clear, `sc_sync` is high only in slot 1, the slot that carries bit 7.
- R5: For a byte whose frame-sync flag is set, `sc_sync` is high in slots 0 and 1, which is one full word-clock period.
- R6: `in_ready` is high exactly when the holding register is empty. A byte and its flag are taken on a clock edge where `in_valid` and `in_ready` are both high, and `in_ready` is low from the next cycle. The holding register is emptied, and `in_ready` rises again, on the edge that starts slot 0 and moves the held byte into the output.
- R7: If the holding register is empty when slot 0 starts, the byte sent is 0x00 with its frame-sync flag clear. The line shows only the start slot high, and sync is high in slot 1 only.
- R8: The block counts `wclk` level changes in a modulo-4 counter that starts at zero on reset. With `upsample` high, only the change that brings this counter from 3 back to 0 advances a slot, so the first advance after reset is on the fourth `wclk` change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wclk | input | 1 | Audio word clock level, synchronous to clk |
| upsample | input | 1 | 1: word clock runs at four times the rate; subcode timing unchanged |
| in_valid | input | 1 | Subcode byte offered |
| in_ready | output | 1 | Holding register empty, byte can be taken |
| in_data | input | 8 | Subcode byte |
| in_fsync | input | 1 | Byte is a subcode frame sync (wide strobe) |
| sc_data | output | 1 | Serial subcode line |
| sc_sync | output | 1 | Sync strobe marking the byte MSB |

## Verification
The bench goes after the byte boundary in several situations. It offers a byte in the same cycle that slot 0 starts, which a design with a bypass or a reversed priority would send one period early or lose. It sends long idle stretches, where a design that resends the stale held byte instead of zero would fail. It mixes frame-sync bytes with normal bytes, which catches a strobe that is one slot too wide or too narrow or sits on the wrong slot. After a second reset it runs in upsampling mode, where a divider with the wrong phase or the wrong ratio moves every slot edge by whole word-clock periods.

// File: rtl/subcode_pkg.sv
package subcode_pkg;
  localparam int SC_BYTE_W = 8;

  typedef struct packed {
    logic [SC_BYTE_W-1:0] data;
    logic                 fsync;
  } sc_byte_t;
endpackage

// File: rtl/sc_slot_tick.sv
module sc_slot_tick #(
  parameter int DIV = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic wclk,
  input  logic upsample,
  output logic tick
);
  localparam int DW = (DIV > 1) ? $clog2(DIV) : 1;

  logic          wclk_q;
  logic [DW-1:0] div_q;
  logic          wedge;

  assign wedge = wclk ^ wclk_q;
  assign tick  = wedge && (!upsample || div_q == DW'(DIV - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      wclk_q <= 1'b0;
      div_q  <= '0;
    end else begin
      wclk_q <= wclk;
      if (wedge) div_q <= (div_q == DW'(DIV - 1)) ? '0 : div_q + 1'b1;
    end
  end

  // R8
  up_tick_needs_edge_chk: assert property (@(posedge clk) disable iff (rst)
    (tick && upsample) |=> (div_q == '0));
endmodule

// File: rtl/sc_hold_reg.sv
module sc_hold_reg
  import subcode_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 in_valid,
  output logic                 in_ready,
  input  logic [SC_BYTE_W-1:0] in_data,
  input  logic                 in_fsync,
  input  logic                 take,
  output logic                 full,
  output sc_byte_t             held
);
  logic accept;

  assign in_ready = !full;
  assign accept   = in_valid && !full;

  always_ff @(posedge clk) begin
    if (rst) begin
      full <= 1'b0;
      held <= '0;
    end else if (accept) begin
      full       <= 1'b1;
      held.data  <= in_data;
      held.fsync <= in_fsync;
    end else if (take) begin
      full <= 1'b0;
    end
  end

  // R6
  accept_blocks_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready) |=> !in_ready);
  // R6
  hold_until_take_chk: assert property (@(posedge clk) disable iff (rst)
    (full && !take) |=> full && $stable(held));
endmodule

// File: rtl/sc_slot_shifter.sv
module sc_slot_shifter
  import subcode_pkg::*;
#(
  parameter int SLOTS = 12
) (
  input  logic     clk,
  input  logic     rst,
  input  logic     tick,
  input  logic     hold_full,
  input  sc_byte_t hold_byte,
  output logic     take,
  output logic     sc_data,
  output logic     sc_sync
);
  localparam int SW = $clog2(SLOTS);

  logic                 started_q;
  logic [SW-1:0]        slot_q, slot_n;
  sc_byte_t             cur_q, cur_n;
  logic                 bit_n;
  logic [SC_BYTE_W-1:0] shifted;

  always_comb begin
    slot_n  = slot_q;
    cur_n   = cur_q;
    take    = 1'b0;
    if (tick) begin
      if (!started_q || slot_q == SW'(SLOTS - 1)) begin
        slot_n = '0;
        take   = 1'b1;
        cur_n  = hold_full ? hold_byte : '0;
      end else begin
        slot_n = slot_q + 1'b1;
      end
    end
    shifted = '0;
    if (slot_n == '0) begin
      bit_n = 1'b1;
    end else if (int'(slot_n) <= SC_BYTE_W) begin
      shifted = cur_n.data << (int'(slot_n) - 1);
      bit_n   = shifted[SC_BYTE_W-1];
    end else begin
      bit_n = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      started_q <= 1'b0;
      slot_q    <= '0;
      cur_q     <= '0;
      sc_data   <= 1'b0;
      sc_sync   <= 1'b0;
    end else if (tick) begin
      started_q <= 1'b1;
      slot_q    <= slot_n;
      cur_q     <= cur_n;
      sc_data   <= bit_n;
      sc_sync   <= (slot_n == SW'(1)) || (cur_n.fsync && slot_n == '0);
    end
  end

  // R1
  idle_before_start_chk: assert property (@(posedge clk) disable iff (rst)
    !started_q |-> (!sc_data && !sc_sync));
  // R3
  start_slot_high_chk: assert property (@(posedge clk) disable iff (rst)
    (started_q && slot_q == '0) |-> sc_data);
  // R3
  tail_slots_low_chk: assert property (@(posedge clk) disable iff (rst)
    (started_q && int'(slot_q) > SC_BYTE_W) |-> !sc_data);
  // R4
  sync_slot_chk: assert property (@(posedge clk) disable iff (rst)
    sc_sync |-> (slot_q <= SW'(1)));
  // R5
  wide_sync_chk: assert property (@(posedge clk) disable iff (rst)
    (started_q && slot_q == '0 && cur_q.fsync) |-> sc_sync);
endmodule

// File: rtl/subcode_serial_out.sv
module subcode_serial_out
  import subcode_pkg::*;
#(
  parameter int SLOTS = 12,
  parameter int DIV   = 4
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 wclk,
  input  logic                 upsample,
  input  logic                 in_valid,
  output logic                 in_ready,
  input  logic [SC_BYTE_W-1:0] in_data,
  input  logic                 in_fsync,
  output logic                 sc_data,
  output logic                 sc_sync
);
  logic     tick;
  logic     take;
  logic     hold_full;
  sc_byte_t hold_byte;

  sc_slot_tick #(.DIV(DIV)) u_tick (
    .clk(clk), .rst(rst), .wclk(wclk), .upsample(upsample), .tick(tick)
  );

  sc_hold_reg u_hold (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_fsync(in_fsync), .take(take),
    .full(hold_full), .held(hold_byte)
  );

  sc_slot_shifter #(.SLOTS(SLOTS)) u_shift (
    .clk(clk), .rst(rst), .tick(tick), .hold_full(hold_full),
    .hold_byte(hold_byte), .take(take), .sc_data(sc_data), .sc_sync(sc_sync)
  );

  // R2
  quiet_between_ticks_chk: assert property (@(posedge clk) disable iff (rst)
    !tick |=> ($stable(sc_data) && $stable(sc_sync)));
  // R6
  ready_returns_on_take_chk: assert property (@(posedge clk) disable iff (rst)
    (take && hold_full) |=> in_ready);
endmodule

// File: tb/subcode_serial_out_test.sv
module subcode_serial_out_test;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG_CYCLES = 150000;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wclk = 1'b0;
  logic       upsample = 1'b0;
  logic       in_valid = 1'b0;
  logic       in_ready;
  logic [7:0] in_data = '0;
  logic       in_fsync = 1'b0;
  logic       sc_data, sc_sync;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  // model state
  bit       m_prev, m_started, m_full, m_hfs, m_fs, m_zero, m_tick;
  int       m_div, m_slot, hcnt;
  bit [7:0] m_hd, m_byte;
  bit       exp_d, exp_s, exp_r, check_on;

  always #(CLK_PERIOD/2) clk = ~clk;

  subcode_serial_out uut (
    .clk(clk), .rst(rst), .wclk(wclk), .upsample(upsample),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .in_fsync(in_fsync), .sc_data(sc_data), .sc_sync(sc_sync)
  );

  function automatic bit slot_bit(int s, bit [7:0] b);
    if (s == 0) return 1'b1;
    if (s <= 8) return b[8 - s];
    return 1'b0;
  endfunction

  function automatic bit slot_sync(int s, bit fs);
    return (s == 1) || (fs && s == 0);
  endfunction

  task automatic check(string req, string what, bit act, bit exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0b expected %0b (slot %0d)", req, what, act, exp, m_slot);
    end
  endtask

  task automatic model_reset();
    m_prev = 0; m_started = 0; m_full = 0; m_hfs = 0; m_fs = 0; m_zero = 0;
    m_div = 0; m_slot = 0; m_hd = 0; m_byte = 0; m_tick = 0;
    exp_d = 0; exp_s = 0; exp_r = 1;
  endtask

  task automatic step(bit allow_valid);
    string rd, rs;
    bit acc, pending;
    @(negedge clk);
    if (check_on) begin
      if (!m_started) begin
        rd = "R1"; rs = "R1";
      end else if (upsample) begin
        rd = "R8"; rs = "R8";
      end else if (!m_tick) begin
        rd = "R2"; rs = "R2";
      end else begin
        rd = m_zero ? "R7" : "R3";
        rs = m_fs ? "R5" : "R4";
      end
      check(rd, "sc_data", sc_data, exp_d);
      check(rs, "sc_sync", sc_sync, exp_s);
      check(m_started ? "R6" : "R1", "in_ready", in_ready, exp_r);
    end
    check_on = 1;
    // drive word clock
    if (hcnt == 0) begin
      wclk = ~wclk;
      hcnt = $urandom_range(1, 4);
    end else hcnt--;
    // drive handshake, holding an offer until accepted
    pending = in_valid && m_full;
    if (!pending) begin
      in_valid = allow_valid && ($urandom_range(0, 9) < 7);
      in_data  = 8'($urandom);
      in_fsync = ($urandom_range(0, 3) == 0);
    end
    acc = in_valid && !m_full;
    // model the coming clock edge
    m_tick = 0;
    if (wclk != m_prev) begin
      m_tick = !upsample || (m_div == 3);
      m_div  = (m_div + 1) % 4;
    end
    m_prev = wclk;
    if (m_tick) begin
      if (!m_started || m_slot == 11) begin
        m_started = 1; m_slot = 0;
        if (m_full) begin
          m_byte = m_hd; m_fs = m_hfs; m_zero = 0; m_full = 0;
        end else begin
          m_byte = 8'h00; m_fs = 0; m_zero = 1;
        end
      end else m_slot++;
      exp_d = slot_bit(m_slot, m_byte);
      exp_s = slot_sync(m_slot, m_fs);
    end
    if (acc) begin
      m_hd = in_data; m_hfs = in_fsync; m_full = 1;
    end
    exp_r = !m_full;
  endtask

  task automatic do_reset(bit ups);
    @(negedge clk);
    rst = 1; wclk = 0; in_valid = 0; upsample = ups;
    repeat (3) @(negedge clk);
    // R1: reset state seen at the ports
    check("R1", "sc_data in reset", sc_data, 1'b0);
    check("R1", "sc_sync in reset", sc_sync, 1'b0);
    check("R1", "in_ready in reset", in_ready, 1'b1);
    rst = 0;
    model_reset();
    hcnt = 3;
    check_on = 0;
  endtask

  initial begin
    void'($urandom(32'd20240611));
    check_on = 0;
    model_reset();
    // normal rate: idle first (R7 zero bytes), then random traffic
    do_reset(1'b0);
    for (int i = 0; i < 200; i++) step(1'b0);
    for (int i = 0; i < 3000; i++) step(1'b1);
    for (int i = 0; i < 150; i++) step(1'b0);
    for (int i = 0; i < 1000; i++) step(1'b1);
    // upsampling mode from a fresh reset (R8)
    do_reset(1'b1);
    for (int i = 0; i < 400; i++) step(1'b0);
    for (int i = 0; i < 6000; i++) step(1'b1);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (WATCHDOG_CYCLES) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule